// File: doc/BRIEF.md
# Vector Bitwise Select Unit

This unit executes two bitwise-select operations on 128-bit SIMD registers. It takes a 32-bit instruction word and recognises one of two encodings. The three-source form builds each result bit from one of two vector sources, steered by a third vector used as a mask. The immediate form uses the old value of the destination register as the mask. For each bit it chooses between one source vector and an 8-bit immediate that is repeated into all sixteen byte lanes.

The unit drives four register-file read indices straight from the instruction fields. The read data comes back on the same cycle and feeds the select logic. The result is registered and leaves one cycle later as a write-back strobe with the destination index and the 128-bit value. A SIMD-enable input gates execution. When the enable is low, a recognised instruction raises a disabled-trap pulse instead of a write-back.

Top module: `vbsel_unit`

## Requirements
- R1: While reset is held, and up to the first accepted instruction, `wb_valid` and `trap_disabled` are 0 and `wb_data` is all zeros.
- R2: A word with bits [31:20] = 12'h0D1 is the three-source select. For every bit position, the result takes the `src_k` bit where `src_a` is 1 and the `src_j` bit where `src_a` is 0. It appears on `wb_data` with `wb_valid` = 1 one clock after the word is presented with `in_valid` = 1.
- R3: The three-source form places the destination in bits [4:0], vj in [9:5], vk in [14:10] and va in [19:15]. `wb_idx` carries bits [4:0] of the accepted word.
- R4: A word with bits [31:18] = 14'b01110011110001 is the immediate select. Its immediate is in bits [17:10], vj in [9:5] and the destination in [4:0]. In every byte lane, each result bit takes the immediate bit where `dst_old` is 1 and the `src_j` bit where `dst_old` is 0. The write-back timing is the same as in R2.
- R5: `rd_d_idx` is bits [4:0] of `insn`, `rd_j_idx` is bits [9:5], `rd_k_idx` is bits [14:10] and `rd_a_idx` is bits [19:15]. These are combinational, so the old destination is read in the same cycle as the sources.
- R6: When a recognised word arrives with `in_valid` = 1 and `simd_en` = 0, `trap_disabled` is 1 for exactly the next cycle. `wb_valid` stays 0 and `wb_data` keeps its previous value.
- R7: A word that matches neither encoding produces neither a write-back nor a trap, and `wb_data` keeps its previous value.
- R8: In a cycle with `in_valid` = 0, the next cycle shows `wb_valid` = 0 and `trap_disabled` = 0, and `wb_data` is unchanged.
- R9: Instructions accepted on consecutive cycles each produce their own one-cycle write-back, in order, with no gap or merging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Decoded instruction word |
| simd_en | input | 1 | SIMD execution enable |
| src_j | input | 128 | Read data for index `rd_j_idx` |
| src_k | input | 128 | Read data for index `rd_k_idx` |
| src_a | input | 128 | Read data for index `rd_a_idx` |
| dst_old | input | 128 | Read data for index `rd_d_idx` (old destination) |
| rd_j_idx | output | 5 | Read index, vj field |
| rd_k_idx | output | 5 | Read index, vk field |
| rd_a_idx | output | 5 | Read index, va field |
| rd_d_idx | output | 5 | Read index, destination field |
| wb_valid | output | 1 | Write-back strobe |
| wb_idx | output | 5 | Write-back destination index |
| wb_data | output | 128 | Write-back value |
| trap_disabled | output | 1 | SIMD-disabled trap pulse |

## Verification
Every registered result (`wb_valid`, `wb_idx`, `wb_data`, `trap_disabled`) is due exactly one rising edge after its instruction is presented. The read indices are due in the same cycle, with no clock between. The driver applies one instruction per cycle on the falling edge and queues one expected record for the edge that follows, including idle and rejected cycles. The monitor pops and compares one record shortly after each rising edge. The read indices are compared combinationally, one nanosecond after each drive.

// File: rtl/vbsel_pkg.sv
package vbsel_pkg;

  localparam int VLEN   = 128;
  localparam int LANE_W = 8;
  localparam int LANES  = VLEN / LANE_W;
  localparam int RIDX_W = 5;
  localparam int IMM_W  = 8;

  localparam int SEL3_OPC_W = 12;
  localparam int SELI_OPC_W = 14;
  localparam logic [SEL3_OPC_W-1:0] SEL3_OPC = 12'h0D1;
  localparam logic [SELI_OPC_W-1:0] SELI_OPC = 14'b01110011110001;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SEL3 = 2'd1,
    OP_SELI = 2'd2
  } sel_op_e;

  typedef struct packed {
    sel_op_e           op;
    logic [RIDX_W-1:0] fd;
    logic [RIDX_W-1:0] fj;
    logic [RIDX_W-1:0] fk;
    logic [RIDX_W-1:0] fa;
    logic [IMM_W-1:0]  imm;
  } sel_dec_t;

  // Classify an instruction word and split out its fields.
  function automatic sel_dec_t crack_word(input logic [31:0] w);
    sel_dec_t d;
    d.fd  = w[4:0];
    d.fj  = w[9:5];
    d.fk  = w[14:10];
    d.fa  = w[19:15];
    d.imm = w[17:10];
    if (w[31:20] == SEL3_OPC)      d.op = OP_SEL3;
    else if (w[31:18] == SELI_OPC) d.op = OP_SELI;
    else                           d.op = OP_NONE;
    return d;
  endfunction

  // Bitwise steering: where steer is 1 take hi, elsewhere take lo.
  function automatic logic [LANE_W-1:0] steer_byte(
      input logic [LANE_W-1:0] steer,
      input logic [LANE_W-1:0] hi,
      input logic [LANE_W-1:0] lo);
    return (steer & hi) | (~steer & lo);
  endfunction

endpackage

// File: rtl/vbsel_decode.sv
module vbsel_decode
  import vbsel_pkg::*;
(
  input  logic [31:0]       insn,
  output sel_dec_t          dec,
  output logic              hit,
  output logic [RIDX_W-1:0] ridx_j,
  output logic [RIDX_W-1:0] ridx_k,
  output logic [RIDX_W-1:0] ridx_a,
  output logic [RIDX_W-1:0] ridx_d
);

  always_comb begin
    dec    = crack_word(insn);
    hit    = (dec.op != OP_NONE);
    ridx_j = dec.fj;
    ridx_k = dec.fk;
    ridx_a = dec.fa;
    ridx_d = dec.fd;
  end

endmodule

// File: rtl/vbsel_datapath.sv
module vbsel_datapath
  import vbsel_pkg::*;
#(
  parameter int W_LANE = LANE_W,
  parameter int N_LANE = LANES,
  parameter int W_IMM  = IMM_W
) (
  input  sel_op_e                    op,
  input  logic [W_IMM-1:0]           imm,
  input  logic [W_LANE*N_LANE-1:0]   vj,
  input  logic [W_LANE*N_LANE-1:0]   vk,
  input  logic [W_LANE*N_LANE-1:0]   va,
  input  logic [W_LANE*N_LANE-1:0]   vd_old,
  output logic [W_LANE*N_LANE-1:0]   result
);

  localparam int VW = W_LANE * N_LANE;

  logic [VW-1:0] sel3_res;
  logic [VW-1:0] seli_res;

  for (genvar ln = 0; ln < N_LANE; ln++) begin : g_lane
    logic [W_LANE-1:0] j_b, k_b, a_b, d_b;
    assign j_b = vj[ln*W_LANE +: W_LANE];
    assign k_b = vk[ln*W_LANE +: W_LANE];
    assign a_b = va[ln*W_LANE +: W_LANE];
    assign d_b = vd_old[ln*W_LANE +: W_LANE];
    // three-source: mask a, 1 -> k, 0 -> j
    assign sel3_res[ln*W_LANE +: W_LANE] = steer_byte(a_b, k_b, j_b);
    // immediate: mask is old destination, 1 -> imm, 0 -> j
    assign seli_res[ln*W_LANE +: W_LANE] = steer_byte(d_b, imm, j_b);
  end

  always_comb begin
    unique case (op)
      OP_SEL3: result = sel3_res;
      OP_SELI: result = seli_res;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/vbsel_wbreg.sv
module vbsel_wbreg
  import vbsel_pkg::*;
#(
  parameter int DW = VLEN,
  parameter int IW = RIDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_wb,
  input  logic          fire_trap,
  input  logic [IW-1:0] idx_in,
  input  logic [DW-1:0] data_in,
  output logic          wb_valid,
  output logic          trap_disabled,
  output logic [IW-1:0] wb_idx,
  output logic [DW-1:0] wb_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid      <= 1'b0;
      trap_disabled <= 1'b0;
      wb_idx        <= '0;
      wb_data       <= '0;
    end else begin
      wb_valid      <= fire_wb;
      trap_disabled <= fire_trap;
      if (fire_wb) begin
        wb_idx  <= idx_in;
        wb_data <= data_in;
      end
    end
  end

endmodule

// File: rtl/vbsel_unit.sv
module vbsel_unit
  import vbsel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [31:0]        insn,
  input  logic               simd_en,
  input  logic [VLEN-1:0]    src_j,
  input  logic [VLEN-1:0]    src_k,
  input  logic [VLEN-1:0]    src_a,
  input  logic [VLEN-1:0]    dst_old,
  output logic [RIDX_W-1:0]  rd_j_idx,
  output logic [RIDX_W-1:0]  rd_k_idx,
  output logic [RIDX_W-1:0]  rd_a_idx,
  output logic [RIDX_W-1:0]  rd_d_idx,
  output logic               wb_valid,
  output logic [RIDX_W-1:0]  wb_idx,
  output logic [VLEN-1:0]    wb_data,
  output logic               trap_disabled
);

  sel_dec_t        dec;
  logic            dec_hit;
  logic            accept;
  logic            go_wb;
  logic            go_trap;
  logic [VLEN-1:0] sel_result;

  vbsel_decode u_dec (
    .insn   (insn),
    .dec    (dec),
    .hit    (dec_hit),
    .ridx_j (rd_j_idx),
    .ridx_k (rd_k_idx),
    .ridx_a (rd_a_idx),
    .ridx_d (rd_d_idx)
  );

  vbsel_datapath #(
    .W_LANE (LANE_W),
    .N_LANE (LANES),
    .W_IMM  (IMM_W)
  ) u_dp (
    .op     (dec.op),
    .imm    (dec.imm),
    .vj     (src_j),
    .vk     (src_k),
    .va     (src_a),
    .vd_old (dst_old),
    .result (sel_result)
  );

  // named events for the checker
  assign accept  = in_valid & dec_hit;
  assign go_wb   = accept & simd_en;
  assign go_trap = accept & ~simd_en;

  vbsel_wbreg #(
    .DW (VLEN),
    .IW (RIDX_W)
  ) u_wb (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire_wb       (go_wb),
    .fire_trap     (go_trap),
    .idx_in        (dec.fd),
    .data_in       (sel_result),
    .wb_valid      (wb_valid),
    .trap_disabled (trap_disabled),
    .wb_idx        (wb_idx),
    .wb_data       (wb_data)
  );

endmodule

// File: rtl/vbsel_chk.sv
module vbsel_chk
  import vbsel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              simd_en,
  input logic [31:0]       insn,
  input logic              accept,
  input logic              wb_valid,
  input logic              trap_disabled,
  input logic [RIDX_W-1:0] wb_idx,
  input logic [VLEN-1:0]   wb_data
);

  // R6
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && trap_disabled));

  // R6
  trap_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !simd_en) |=> (trap_disabled && !wb_valid));

  // R2
  wb_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && simd_en) |=> wb_valid);

  // R3
  wb_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && simd_en) |=> (wb_idx == $past(insn[4:0])));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!wb_valid && !trap_disabled && $stable(wb_data)));

  // R7
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !accept) |=> (!wb_valid && !trap_disabled));

endmodule

bind vbsel_unit vbsel_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .simd_en       (simd_en),
  .insn          (insn),
  .accept        (accept),
  .wb_valid      (wb_valid),
  .trap_disabled (trap_disabled),
  .wb_idx        (wb_idx),
  .wb_data       (wb_data)
);

// File: tb/vbsel_unit_tb_top.sv
`timescale 1ns/1ps
module vbsel_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic         simd_en = 1'b1;
  logic [127:0] src_j = '0, src_k = '0, src_a = '0, dst_old = '0;
  logic [4:0]   rd_j_idx, rd_k_idx, rd_a_idx, rd_d_idx;
  logic         wb_valid;
  logic [4:0]   wb_idx;
  logic [127:0] wb_data;
  logic         trap_disabled;

  always #2.5 clk = ~clk;

  vbsel_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .simd_en(simd_en), .src_j(src_j), .src_k(src_k), .src_a(src_a),
    .dst_old(dst_old), .rd_j_idx(rd_j_idx), .rd_k_idx(rd_k_idx),
    .rd_a_idx(rd_a_idx), .rd_d_idx(rd_d_idx), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data), .trap_disabled(trap_disabled)
  );

  typedef struct {
    logic         v;
    logic         t;
    logic [4:0]   idx;
    logic [127:0] data;
    string        tag;
  } exp_t;

  exp_t         sb_q[$];
  int           n_chk = 0;
  int           n_bad = 0;
  logic [127:0] held_data = '0;
  logic [4:0]   held_idx = '0;
  bit           done = 0;

  // reference: bit-by-bit steering
  function automatic logic [127:0] ref_three(logic [127:0] m, logic [127:0] k, logic [127:0] j);
    logic [127:0] r;
    for (int b = 0; b < 128; b++) r[b] = m[b] ? k[b] : j[b];
    return r;
  endfunction

  function automatic logic [127:0] ref_imm(logic [127:0] old, logic [127:0] j, logic [7:0] im);
    logic [127:0] r;
    for (int b = 0; b < 128; b++) r[b] = old[b] ? im[b % 8] : j[b];
    return r;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one instruction per cycle; push the expected record for the next edge
  task automatic issue(bit vld, logic [31:0] w, bit en,
                       logic [127:0] j, logic [127:0] k, logic [127:0] a,
                       logic [127:0] d, int kind, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = vld; insn = w; simd_en = en;
    src_j = j; src_k = k; src_a = a; dst_old = d;
    e.tag = tag; e.v = 0; e.t = 0;
    if (vld && kind != 0 && en) begin
      e.v = 1;
      held_idx  = w[4:0];
      held_data = (kind == 1) ? ref_three(a, k, j) : ref_imm(d, j, w[17:10]);
    end else if (vld && kind != 0) begin
      e.t = 1;
    end
    e.idx = held_idx; e.data = held_data;
    sb_q.push_back(e);
    #1;
    // R5 read indices are combinational
    check({rd_d_idx, rd_j_idx, rd_k_idx, rd_a_idx} == {w[4:0], w[9:5], w[14:10], w[19:15]},
          "R5", "read idx", {rd_d_idx, rd_j_idx, rd_k_idx, rd_a_idx},
          {w[4:0], w[9:5], w[14:10], w[19:15]});
  endtask

  function automatic logic [31:0] w3(logic [4:0] va, logic [4:0] vk, logic [4:0] vj, logic [4:0] vd);
    return {12'h0D1, va, vk, vj, vd};
  endfunction

  function automatic logic [31:0] wi(logic [7:0] im, logic [4:0] vj, logic [4:0] vd);
    return {14'b01110011110001, im, vj, vd};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  // monitor: pop and compare just after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(wb_valid == e.v, e.tag, "wb_valid", 128'(wb_valid), 128'(e.v));
      check(trap_disabled == e.t, e.tag, "trap", 128'(trap_disabled), 128'(e.t));
      check(wb_data == e.data, e.tag, "wb_data", wb_data, e.data);
      if (e.v) check(wb_idx == e.idx, e.tag, "wb_idx", 128'(wb_idx), 128'(e.idx));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [127:0] ones;
    ones = '1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!wb_valid && !trap_disabled && wb_data == '0, "R1", "reset",
          {wb_valid, trap_disabled, wb_data[125:0]}, '0);
    @(negedge clk); rst_n = 1'b1;

    // R8 idle after reset, R1 state persists
    issue(0, 32'h0, 1, '0, '0, '0, '0, 0, "R1");
    issue(0, w3(5'd1, 5'd2, 5'd3, 5'd4), 1, ones, ones, ones, ones, 0, "R8");

    // R2 mask all ones -> k, all zeros -> j, mixed
    issue(1, w3(5'd1, 5'd2, 5'd3, 5'd4), 1, 128'hAAAA, 128'h5555_0000_FFFF, ones, '0, 1, "R2");
    issue(1, w3(5'd9, 5'd8, 5'd7, 5'd31), 1, 128'h1234_5678, rnd128(), '0, '0, 1, "R2");
    issue(1, w3(5'd0, 5'd17, 5'd22, 5'd13), 1, rnd128(), rnd128(), {8{16'hF00F}}, '0, 1, "R3");
    for (int i = 0; i < 20; i++)
      issue(1, w3(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom)), 1,
            rnd128(), rnd128(), rnd128(), rnd128(), 1, "R9");

    // R4 immediate form: zero old -> j, all-ones old -> broadcast imm
    issue(1, wi(8'hC3, 5'd6, 5'd10), 1, rnd128(), rnd128(), rnd128(), '0, 2, "R4");
    issue(1, wi(8'hC3, 5'd6, 5'd11), 1, rnd128(), rnd128(), rnd128(), ones, 2, "R4");
    issue(1, wi(8'h00, 5'd1, 5'd2), 1, ones, '0, '0, {16{8'h0F}}, 2, "R4");
    issue(1, wi(8'hFF, 5'd1, 5'd2), 1, '0, '0, '0, {16{8'hF0}}, 2, "R4");
    for (int i = 0; i < 20; i++)
      issue(1, wi(8'($urandom), 5'($urandom), 5'($urandom)), 1,
            rnd128(), rnd128(), rnd128(), rnd128(), 2, "R9");

    // R6 disabled: trap, no write-back, data held
    issue(1, w3(5'd1, 5'd2, 5'd3, 5'd5), 0, ones, '0, ones, '0, 1, "R6");
    issue(1, wi(8'h5A, 5'd2, 5'd7), 0, rnd128(), '0, '0, ones, 2, "R6");
    issue(1, w3(5'd1, 5'd2, 5'd3, 5'd6), 1, ones, '0, '0, '0, 1, "R6");

    // R7 unrecognised words
    issue(1, 32'hFFFF_FFFF, 1, ones, ones, ones, ones, 0, "R7");
    issue(1, {12'h0D0, 20'hABCDE}, 1, ones, ones, ones, ones, 0, "R7");
    issue(1, {14'b01110011110011, 18'h3FFFF}, 0, ones, ones, ones, ones, 0, "R7");

    // R8 idle with a valid-looking word
    issue(0, wi(8'hFF, 5'd1, 5'd2), 1, '0, '0, '0, ones, 0, "R8");
    issue(0, 32'h0, 1, '0, '0, '0, '0, 0, "R8");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule